// File: doc/BRIEF.md
# Bit-Aligned Pattern Search Engine

The engine watches a byte-wide stream for one fixed bit pattern that may start at any of the eight bit positions inside a byte. A pattern of 1 to `8*MAX_BYTES` bits is loaded first, one byte per cycle after a start pulse that carries its length in bits. When loading finishes, the engine holds one image of the pattern for each bit offset, together with a mask that blanks the bits before the first pattern bit and after the last one. Each byte that then arrives is compared against all eight masked images in parallel. Inside a byte, the first bit in stream order is bit 7.

The stream input is valid/ready. `s_ready_o` is high whenever a pattern is loaded and no load is starting, so the engine never applies back-pressure while it searches. A byte is consumed only in a cycle where `s_valid_i` and `s_ready_o` are both high. The engine keeps no copy of the stream beyond the sliding window that the compare needs. It reports one match per stream byte position, giving that position and the lowest bit offset that matches.

Top module: `bsrch_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, `s_ready_o` and `match_o` are low.
- R2: A load starts with a one-cycle `ld_start_i` that carries the length L in bits on `ld_nbits_i`. It then takes ceil(L/8) bytes on `ld_data_i`, one in each cycle where `ld_valid_i` is high. Bit 7 of the first loaded byte is pattern bit 0. `s_ready_o` goes high in the cycle after the last pattern byte is taken.
- R3: Stream byte n is the n-th byte consumed since the last load, counting from 0. A match at position p and offset k means that, for every i < L, bit 7-((k+i) mod 8) of stream byte p+(k+i) div 8 equals pattern bit i.
- R4: Let S = floor((L+14)/8). A match at position p is reported in the cycle right after stream byte p+S-1 is consumed. In that cycle `match_o` is 1, `match_pos_o` is p and `match_off_o` is k. No match is reported before S bytes have been consumed.
- R5: When several offsets match at the same position, `match_off_o` gives the lowest of them.
- R6: Every pattern bit takes part in the compare, so a stream that differs from the pattern in one bit does not match.
- R7: The bits of the last loaded byte that lie beyond L have no effect on matching.
- R8: A new load clears the sliding window and the position count. Bytes consumed before the load never form part of a later match, and positions start again from 0.
- R9: `s_ready_o` is low before the first load completes, during a load, and in any cycle where `ld_start_i` is high. A byte offered in those cycles is not consumed and does not move the position count.
- R10: Once a pattern is loaded, `s_ready_o` stays high in every cycle until the next `ld_start_i`.
- R11: `match_o` is high only in the cycle that follows a consumed stream byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_start_i | input | 1 | Starts a pattern load and clears the search state |
| ld_nbits_i | input | LEN_W | Pattern length in bits, sampled together with `ld_start_i` |
| ld_valid_i | input | 1 | Pattern byte present on `ld_data_i` |
| ld_data_i | input | 8 | Pattern byte, first pattern bit in bit 7 |
| s_valid_i | input | 1 | Stream byte offered |
| s_ready_o | output | 1 | Engine consumes the offered byte |
| s_data_i | input | 8 | Stream byte |
| match_o | output | 1 | Match found at the position ending with the last consumed byte |
| match_pos_o | output | POS_W | Stream byte index where the match begins |
| match_off_o | output | 3 | Bit offset of the match inside that byte |

## Verification
A load request and a stream byte can fall in the same cycle. The bench raises `ld_start_i` while `s_valid_i` is held high, and it keeps offering bytes through a whole load. It judges the outcome in two ways. The first is that `s_ready_o` reads low in those cycles. The second is that the first match after the load is reported at position 0 with the expected offset, which could not happen if any offered byte had moved the count. A second same-cycle case is several offsets matching at one position. This is provoked with a periodic pattern and checked by requiring the lowest offset.

// File: rtl/bsrch_pkg.sv
package bsrch_pkg;
  localparam int BYTE_W = 8;
  localparam int N_OFF  = 8;
  localparam int OFF_W  = 3;

  typedef enum logic [1:0] {
    ST_EMPTY,
    ST_LOAD,
    ST_RUN
  } ld_state_e;
endpackage

// File: rtl/bsrch_loader.sv
module bsrch_loader
  import bsrch_pkg::*;
#(
  parameter int MAX_BYTES = 40,
  parameter int LEN_W     = 9,
  parameter int WB        = 328,
  parameter int SPN_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_start,
  input  logic [LEN_W-1:0] ld_nbits,
  input  logic             ld_valid,
  input  logic [7:0]       ld_data,
  output logic             loaded_o,
  output logic [WB-1:0]    img_o,
  output logic [WB-1:0]    msk_o,
  output logic [SPN_W-1:0] spn_o
);
  localparam int BW = $clog2(WB);

  ld_state_e        state_q;
  logic [SPN_W-1:0] spn_q, nb_q, idx_q;
  logic [WB-1:0]    img_q, msk_q, msk_d;
  logic [BW-1:0]    wr_base;
  int               len_i, top_i;

  // Window span in bits: enough bytes to hold the pattern at offset 7.
  assign len_i = int'(ld_nbits);
  assign top_i = ((len_i + 14) / 8) * 8;

  always_comb begin
    for (int q = 0; q < WB; q++) begin
      msk_d[q] = (q >= top_i - len_i) && (q < top_i);
    end
  end

  // Pattern byte n sits at window depth S-1-n.
  assign wr_base = BW'(spn_q - SPN_W'(1) - idx_q) << 3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_EMPTY;
      spn_q   <= '0;
      nb_q    <= '0;
      idx_q   <= '0;
      img_q   <= '0;
      msk_q   <= '0;
    end else if (ld_start) begin
      state_q <= ST_LOAD;
      spn_q   <= SPN_W'((len_i + 14) / 8);
      nb_q    <= SPN_W'((len_i + 7) / 8);
      idx_q   <= '0;
      img_q   <= '0;
      msk_q   <= msk_d;
    end else if (state_q == ST_LOAD && ld_valid) begin
      img_q[wr_base +: 8] <= ld_data;
      idx_q               <= idx_q + SPN_W'(1);
      if (idx_q == nb_q - SPN_W'(1)) state_q <= ST_RUN;
    end
  end

  assign loaded_o = (state_q == ST_RUN);
  assign img_o    = img_q;
  assign msk_o    = msk_q;
  assign spn_o    = spn_q;

  // R2
  load_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loaded_o) |-> $past(ld_valid));
  // R9
  load_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_start |=> !loaded_o);
endmodule

// File: rtl/bsrch_lane.sv
module bsrch_lane #(
  parameter int WB    = 328,
  parameter int SHIFT = 0
) (
  input  logic [WB-1:0] win_i,
  input  logic [WB-1:0] img_i,
  input  logic [WB-1:0] msk_i,
  output logic          hit_o
);
  logic [WB-1:0] img_s, msk_s;

  // A later bit offset moves the image toward newer stream bits.
  assign img_s = img_i >> SHIFT;
  assign msk_s = msk_i >> SHIFT;
  assign hit_o = ~|((win_i ^ img_s) & msk_s);
endmodule

// File: rtl/bsrch_pick.sv
module bsrch_pick
  import bsrch_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_OFF-1:0] hits_i,
  output logic             any_o,
  output logic [OFF_W-1:0] off_o
);
  always_comb begin
    off_o = '0;
    for (int k = N_OFF - 1; k >= 0; k--) begin
      if (hits_i[k]) off_o = OFF_W'(k);
    end
  end

  assign any_o = |hits_i;

  // R5
  lowest_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> (hits_i[off_o] &&
               ((hits_i & ((N_OFF'(1) << off_o) - N_OFF'(1))) == '0)));
endmodule

// File: rtl/bsrch_engine.sv
module bsrch_engine
  import bsrch_pkg::*;
#(
  parameter  int MAX_BYTES = 40,
  parameter  int POS_W     = 16,
  localparam int LEN_W     = $clog2(MAX_BYTES * 8 + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_start_i,
  input  logic [LEN_W-1:0] ld_nbits_i,
  input  logic             ld_valid_i,
  input  logic [7:0]       ld_data_i,
  input  logic             s_valid_i,
  output logic             s_ready_o,
  input  logic [7:0]       s_data_i,
  output logic             match_o,
  output logic [POS_W-1:0] match_pos_o,
  output logic [2:0]       match_off_o
);
  localparam int NW    = MAX_BYTES + 1;
  localparam int WB    = NW * BYTE_W;
  localparam int SPN_W = $clog2(NW + 1);

  logic             loaded;
  logic [WB-1:0]    img, msk, win_q;
  logic [SPN_W-1:0] spn;
  logic [POS_W-1:0] cnt_q;
  logic             acc_q, take, full, any;
  logic [N_OFF-1:0] hits;
  logic [OFF_W-1:0] off;

  bsrch_loader #(
    .MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W), .WB(WB), .SPN_W(SPN_W)
  ) u_loader (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_start (ld_start_i),
    .ld_nbits (ld_nbits_i),
    .ld_valid (ld_valid_i),
    .ld_data  (ld_data_i),
    .loaded_o (loaded),
    .img_o    (img),
    .msk_o    (msk),
    .spn_o    (spn)
  );

  assign s_ready_o = loaded && !ld_start_i;
  assign take      = s_valid_i && s_ready_o;

  // Newest byte enters at the low end; the flat window reads in stream order
  // from the top bit down.
  always_ff @(posedge clk) begin
    if (!rst_n || ld_start_i) begin
      win_q <= '0;
      cnt_q <= '0;
      acc_q <= 1'b0;
    end else begin
      acc_q <= take;
      if (take) begin
        win_q <= {win_q[WB-BYTE_W-1:0], s_data_i};
        cnt_q <= cnt_q + POS_W'(1);
      end
    end
  end

  for (genvar k = 0; k < N_OFF; k++) begin : g_lane
    bsrch_lane #(.WB(WB), .SHIFT(k)) u_lane (
      .win_i (win_q),
      .img_i (img),
      .msk_i (msk),
      .hit_o (hits[k])
    );
  end

  bsrch_pick u_pick (
    .clk    (clk),
    .rst_n  (rst_n),
    .hits_i (hits),
    .any_o  (any),
    .off_o  (off)
  );

  assign full        = cnt_q >= POS_W'(spn);
  assign match_o     = acc_q && full && any;
  assign match_pos_o = cnt_q - POS_W'(spn);
  assign match_off_o = off;

  // R11
  match_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> $past(s_valid_i && s_ready_o));
  // R10
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(s_ready_o) && !ld_start_i) |-> s_ready_o);
  // R4
  pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !ld_start_i) |=> (cnt_q == $past(cnt_q) + POS_W'(1)));
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> (!s_ready_o && !match_o));
endmodule

// File: tb/test_bsrch_engine.sv
module test_bsrch_engine;
  typedef struct packed {
    logic [7:0]  d;
    logic        h;
    logic [15:0] p;
    logic [2:0]  k;
  } vec_t;

  // Pattern 0xB4 (8 bits), window span 2 bytes.
  localparam vec_t VECS [11] = '{
    '{8'h00, 1'b0, 16'd0, 3'd0},
    '{8'hB4, 1'b0, 16'd0, 3'd0},
    '{8'h00, 1'b1, 16'd1, 3'd0},
    '{8'h16, 1'b0, 16'd0, 3'd0},
    '{8'h80, 1'b1, 16'd3, 3'd3},
    '{8'h5A, 1'b0, 16'd0, 3'd0},
    '{8'h00, 1'b1, 16'd5, 3'd1},
    '{8'h01, 1'b0, 16'd0, 3'd0},
    '{8'h68, 1'b1, 16'd7, 3'd7},
    '{8'hB5, 1'b0, 16'd0, 3'd0},
    '{8'h00, 1'b0, 16'd0, 3'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_start = 1'b0;
  logic [8:0]  ld_nbits = '0;
  logic        ld_valid = 1'b0;
  logic [7:0]  ld_data = '0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [7:0]  s_data = '0;
  logic        match;
  logic [15:0] match_pos;
  logic [2:0]  match_off;

  int checks = 0;
  int errors = 0;
  logic [7:0] pat_b [40];
  logic [7:0] str_b [23];

  always #5 clk = ~clk;

  bsrch_engine i_bsrch_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .ld_start_i  (ld_start),
    .ld_nbits_i  (ld_nbits),
    .ld_valid_i  (ld_valid),
    .ld_data_i   (ld_data),
    .s_valid_i   (s_valid),
    .s_ready_o   (s_ready),
    .s_data_i    (s_data),
    .match_o     (match),
    .match_pos_o (match_pos),
    .match_off_o (match_off)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expect_out(string req, bit h, int p, int k);
    check(req, int'(match), int'(h));
    if (h) begin
      check(req, int'(match_pos), p);
      check(req, int'(match_off), k);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // Load nbits from pat_b; optionally offer stream bytes throughout.
  task automatic load(int nbits, bit offer);
    int nb;
    nb = (nbits + 7) / 8;
    ld_start = 1'b1;
    ld_nbits = 9'(nbits);
    if (offer) begin
      s_valid = 1'b1;
      s_data  = 8'hFF;
    end
    #1;
    check("R9 ready low with load start", int'(s_ready), 0);
    @(posedge clk);
    @(negedge clk);
    ld_start = 1'b0;
    for (int i = 0; i < nb; i++) begin
      ld_valid = 1'b1;
      ld_data  = pat_b[i];
      #1;
      check("R2 R9 ready low while loading", int'(s_ready), 0);
      @(posedge clk);
      @(negedge clk);
    end
    ld_valid = 1'b0;
    s_valid  = 1'b0;
    check("R2 ready after last pattern byte", int'(s_ready), 1);
  endtask

  task automatic send(logic [7:0] b);
    s_valid = 1'b1;
    s_data  = b;
    #1;
    check("R10 ready while searching", int'(s_ready), 1);
    @(posedge clk);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 ready in reset", int'(s_ready), 0);
    check("R1 match in reset", int'(match), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", int'(s_ready), 0);
    check("R1 match after reset", int'(match), 0);

    // R3 R4 R6 table walk, pattern 0xB4
    pat_b[0] = 8'hB4;
    load(8, 1'b0);
    for (int i = 0; i < 11; i++) begin
      send(VECS[i].d);
      expect_out("R3 R4 R6 table", VECS[i].h, int'(VECS[i].p), int'(VECS[i].k));
    end

    // R11 idle cycle gives no match
    @(negedge clk);
    check("R11 no match without byte", int'(match), 0);

    // R8 reload clears window and count
    send(8'hB4);
    expect_out("R8 before reload", 1'b0, 0, 0);
    load(8, 1'b0);
    send(8'h00);
    expect_out("R8 window cleared", 1'b0, 0, 0);
    send(8'h00);
    expect_out("R8 window cleared", 1'b0, 0, 0);
    send(8'hB4);
    expect_out("R8 restart", 1'b0, 0, 0);
    send(8'h00);
    expect_out("R8 position restarts", 1'b1, 2, 0);

    // R7 padding bits ignored: pattern 1011 loaded as 0xBF
    pat_b[0] = 8'hBF;
    load(4, 1'b0);
    send(8'h00);
    send(8'hB0);
    expect_out("R7 padding", 1'b0, 0, 0);
    send(8'h00);
    expect_out("R7 padding ignored", 1'b1, 1, 0);

    // R9 R5 bytes offered during load are not taken; lowest offset wins
    pat_b[0] = 8'hAA;
    s_valid = 1'b1;
    s_data  = 8'h55;
    load(8, 1'b1);
    send(8'h55);
    expect_out("R9 no early match", 1'b0, 0, 0);
    send(8'h55);
    expect_out("R5 R9 lowest offset at position 0", 1'b1, 0, 1);

    // R3 R4 long pattern, 160 bits at position 2 offset 5, span 21
    for (int i = 0; i < 20; i++) pat_b[i] = 8'(i * 37 + 11);
    for (int j = 0; j < 23; j++) str_b[j] = 8'h00;
    for (int i = 0; i < 160; i++) begin
      int t;
      t = 21 + i;
      str_b[t / 8][7 - (t % 8)] = pat_b[i / 8][7 - (i % 8)];
    end
    load(160, 1'b0);
    for (int j = 0; j < 22; j++) begin
      send(str_b[j]);
      checks++;
      if (match !== 1'b0) begin
        errors++;
        $display("FAIL R4 early match at byte %0d actual %0d expected 0", j, match);
      end
    end
    send(str_b[22]);
    expect_out("R3 R4 long pattern", 1'b1, 2, 5);

    summary();
    $finish;
  end
endmodule